// File: doc/BRIEF.md
# Calibrated Real-Time Seconds Counter

This core keeps wall-clock time as a 32-bit count of seconds. It runs directly on the slow crystal clock: every clock cycle is one crystal tick. A programmable divider turns ticks into one-second strobes. An optional fractional stretch adds single ticks to some seconds, so a crystal whose rate is not a whole number of hertz can still be trimmed.

Software reaches the core through a 32-bit register port. Writes take effect on the clock edge. Reads are combinational and have no side effects. Software can set the time, read it back, and program the divider calibration. It can also arm a seconds alarm, handle two sticky event flags (second and alarm) that are cleared by writing 1, and mask or unmask each flag. It can keep two control bits that other logic uses. A single interrupt line reports every event that is set and not masked.

A new time does not take effect at once. It is held pending and copied into the counter on the next second strobe. Writing the calibration register restarts the divider, so the strobe after such a write comes exactly one full second later. Software uses this to line the second boundary up with its own write.

Top module: `rtc_seconds_core`

## Requirements
- R1: After reset the current time, tick count and event flags are zero, both mask bits are 1, the control register reads zero, calibration reads the `CAL_DEFAULT` parameter and `irq` is low.
- R2: The calibration word holds the tick limit in bits 15:0, the fraction in bits 19:16 and the fraction enable in bit 20. With the fraction enable clear, a second lasts (limit + 1) clock cycles, and the current time (offset 0x10) goes up by one at the end of each second.
- R3: With the fraction enable set and fraction F, the divider counts seconds in groups of 16 using a phase index that starts at 0. Each second whose phase index is below F lasts one extra cycle.
- R4: A write to calibration (offset 0x08) stores bits 20:0 and clears the tick counter and the phase index, so the next second ends exactly one full period after the write. The readback at 0x0C returns the stored 21 bits, with zeros above them.
- R5: A write to set-time (offset 0x00) leaves the current time unchanged until the next second strobe, which loads the written value. Offset 0x04 returns the last value written.
- R6: Event flag bit 0 (offset 0x20) is set on every second strobe. Writing 1 to a flag bit clears it. If a strobe and a clear land on the same edge, the set wins.
- R7: Event flag bit 1 is set on the strobe whose new time equals the alarm register (offset 0x18, readable).
- R8: Writing 1 to a bit at offset 0x28 clears that mask bit. Writing 1 to a bit at offset 0x2C sets it. Writing 0 leaves the bit unchanged. The mask reads at 0x24.
- R9: `irq` is high exactly when some event flag is set and its mask bit is 0.
- R10: The control register (offset 0x40) stores only bit 31 and bit 24. Every other bit reads as zero.
- R11: Offset 0x14 returns the divider's running tick count, which starts at 0 after a restart and rises by one per cycle.
- R12: Offsets outside the map read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal tick clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Unmasked event present |

## Verification
The bench builds the core with `CAL_DEFAULT` set to a tick limit of 4 and no fraction, so each second lasts five cycles. This makes second boundaries, alarm matches and clear-versus-set collisions reachable within a few dozen cycles, and makes each one easy to pin to an exact edge. It then writes fractional calibration words, which bring the stretched seconds and the restart timing within reach at the same small scale. The full 16-bit tick limit and the 32-bit seconds width stay at their default values.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int TICK_W = 16;
    localparam int FRAC_W = 4;
    localparam int CAL_W  = TICK_W + FRAC_W + 1;
    localparam int EVT_N  = 2;

    localparam int EVT_SEC = 0;
    localparam int EVT_ALM = 1;
    localparam int CTL_BATT = 31;
    localparam int CTL_OSC  = 24;

    localparam logic [ADDR_W-1:0] OFS_SET_WR = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_SET_RD = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CAL_WR = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CAL_RD = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_TIME   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_TICK   = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_ALARM  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_EVT    = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_UNMASK = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_DOMASK = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h40;

    typedef struct packed {
        logic              fr_en;
        logic [FRAC_W-1:0] frac;
        logic [TICK_W-1:0] ticks;
    } calib_t;

    typedef struct packed {
        logic set_time;
        logic calib;
        logic alarm;
        logic evt_clr;
        logic unmask;
        logic domask;
        logic ctrl;
    } wsel_t;

    function automatic wsel_t decode_write(input logic we, input logic [ADDR_W-1:0] a);
        wsel_t s;
        s.set_time = we && (a == OFS_SET_WR);
        s.calib    = we && (a == OFS_CAL_WR);
        s.alarm    = we && (a == OFS_ALARM);
        s.evt_clr  = we && (a == OFS_EVT);
        s.unmask   = we && (a == OFS_UNMASK);
        s.domask   = we && (a == OFS_DOMASK);
        s.ctrl     = we && (a == OFS_CTRL);
        return s;
    endfunction
endpackage

// File: rtl/rtcc_divider.sv
module rtcc_divider
    import rtcc_pkg::*;
#(
    parameter int TW = TICK_W,
    parameter int FW = FRAC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [TW-1:0] ticks,
    input  logic [FW-1:0] frac,
    input  logic          fr_en,
    output logic [TW:0]   tick_cnt,
    output logic          sec_stb
);
    logic [FW-1:0] phase;
    logic          stretch;
    logic [TW:0]   limit;
    logic          at_limit;

    always_comb begin
        stretch  = fr_en && (phase < frac);
        limit    = {1'b0, ticks} + {{TW{1'b0}}, stretch};
        at_limit = (tick_cnt == limit);
        sec_stb  = at_limit && !restart;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            tick_cnt <= '0;
            phase    <= '0;
        end else if (at_limit) begin
            tick_cnt <= '0;
            phase    <= phase + 1'b1;
        end else begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    // R2: the tick count never passes the current second's limit
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        tick_cnt <= limit);
    // R4: a calibration write restarts both counters
    p_restart_r4: assert property (@(posedge clk) disable iff (rst)
        restart |=> (tick_cnt == '0) && (phase == '0));
    // R3: the phase index moves only at a second boundary
    p_phase_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!sec_stb && !restart) |=> $stable(phase));
endmodule

// File: rtl/rtcc_timekeep.sv
module rtcc_timekeep
    import rtcc_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sec_stb,
    input  logic          set_wr,
    input  logic          alarm_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] secs,
    output logic [DW-1:0] set_val,
    output logic [DW-1:0] alarm_val,
    output logic          alarm_evt
);
    logic          pending;
    logic [DW-1:0] secs_next;

    always_comb begin
        secs_next = pending ? set_val : secs + 1'b1;
        alarm_evt = sec_stb && (secs_next == alarm_val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            secs      <= '0;
            set_val   <= '0;
            alarm_val <= '0;
            pending   <= 1'b0;
        end else begin
            if (sec_stb) secs <= secs_next;
            if (set_wr) begin
                set_val <= wdata;
                pending <= 1'b1;
            end else if (sec_stb) begin
                pending <= 1'b0;
            end
            if (alarm_wr) alarm_val <= wdata;
        end
    end

    // R5: time moves only on a second strobe
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !sec_stb |=> $stable(secs));
    // R5: a pending value is what the strobe loads
    p_load_r5: assert property (@(posedge clk) disable iff (rst)
        (sec_stb && pending) |=> secs == $past(set_val));
    // R2: without a pending value the strobe counts up by one
    p_count_r2: assert property (@(posedge clk) disable iff (rst)
        (sec_stb && !pending) |=> secs == $past(secs) + 1'b1);
endmodule

// File: rtl/rtcc_events.sv
module rtcc_events
    import rtcc_pkg::*;
#(
    parameter int N = EVT_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sec_evt,
    input  logic         alarm_evt,
    input  logic         clr_wr,
    input  logic         unmask_wr,
    input  logic         domask_wr,
    input  logic [N-1:0] wbits,
    output logic [N-1:0] flags,
    output logic [N-1:0] mask,
    output logic         irq
);
    logic [N-1:0] raise;
    logic [N-1:0] clr;

    always_comb begin
        raise          = '0;
        raise[EVT_SEC] = sec_evt;
        raise[EVT_ALM] = alarm_evt;
        clr            = clr_wr ? wbits : '0;
        irq            = |(flags & ~mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            mask  <= '1;
        end else begin
            flags <= (flags & ~clr) | raise;
            if (unmask_wr) mask <= mask & ~wbits;
            else if (domask_wr) mask <= mask | wbits;
        end
    end

    // R6: a second event always leaves its flag set
    p_sec_flag_r6: assert property (@(posedge clk) disable iff (rst)
        sec_evt |=> flags[EVT_SEC]);
    // R6: a clear with no competing event removes the flag
    p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && wbits[EVT_SEC] && !sec_evt) |=> !flags[EVT_SEC]);
    // R7: alarm event raises its flag
    p_alm_flag_r7: assert property (@(posedge clk) disable iff (rst)
        alarm_evt |=> flags[EVT_ALM]);
    // R8: unmask and mask writes act on the mask
    p_unmask_r8: assert property (@(posedge clk) disable iff (rst)
        (unmask_wr && wbits[EVT_ALM]) |=> !mask[EVT_ALM]);
    p_domask_r8: assert property (@(posedge clk) disable iff (rst)
        (domask_wr && wbits[EVT_ALM]) |=> mask[EVT_ALM]);
endmodule

// File: rtl/rtc_seconds_core.sv
module rtc_seconds_core
    import rtcc_pkg::*;
#(
    parameter logic [CAL_W-1:0] CAL_DEFAULT = 21'h198233
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    wsel_t             ws;
    calib_t            calib;
    logic              ctl_batt;
    logic              ctl_osc;
    logic [TICK_W:0]   tick_cnt;
    logic              sec_stb;
    logic [DATA_W-1:0] secs;
    logic [DATA_W-1:0] set_val;
    logic [DATA_W-1:0] alarm_val;
    logic              alarm_evt;
    logic [EVT_N-1:0]  flags;
    logic [EVT_N-1:0]  mask;

    assign ws = decode_write(reg_we, reg_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            calib    <= CAL_DEFAULT;
            ctl_batt <= 1'b0;
            ctl_osc  <= 1'b0;
        end else begin
            if (ws.calib) calib <= reg_wdata[CAL_W-1:0];
            if (ws.ctrl) begin
                ctl_batt <= reg_wdata[CTL_BATT];
                ctl_osc  <= reg_wdata[CTL_OSC];
            end
        end
    end

    rtcc_divider #(.TW(TICK_W), .FW(FRAC_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .restart  (ws.calib),
        .ticks    (calib.ticks),
        .frac     (calib.frac),
        .fr_en    (calib.fr_en),
        .tick_cnt (tick_cnt),
        .sec_stb  (sec_stb)
    );

    rtcc_timekeep #(.DW(DATA_W)) u_time (
        .clk       (clk),
        .rst       (rst),
        .sec_stb   (sec_stb),
        .set_wr    (ws.set_time),
        .alarm_wr  (ws.alarm),
        .wdata     (reg_wdata),
        .secs      (secs),
        .set_val   (set_val),
        .alarm_val (alarm_val),
        .alarm_evt (alarm_evt)
    );

    rtcc_events #(.N(EVT_N)) u_evt (
        .clk       (clk),
        .rst       (rst),
        .sec_evt   (sec_stb),
        .alarm_evt (alarm_evt),
        .clr_wr    (ws.evt_clr),
        .unmask_wr (ws.unmask),
        .domask_wr (ws.domask),
        .wbits     (reg_wdata[EVT_N-1:0]),
        .flags     (flags),
        .mask      (mask),
        .irq       (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_SET_RD: reg_rdata = set_val;
            OFS_CAL_RD: reg_rdata = DATA_W'(calib);
            OFS_TIME:   reg_rdata = secs;
            OFS_TICK:   reg_rdata = DATA_W'(tick_cnt);
            OFS_ALARM:  reg_rdata = alarm_val;
            OFS_EVT:    reg_rdata = DATA_W'(flags);
            OFS_MASK:   reg_rdata = DATA_W'(mask);
            OFS_CTRL: begin
                reg_rdata[CTL_BATT] = ctl_batt;
                reg_rdata[CTL_OSC]  = ctl_osc;
            end
            default:    reg_rdata = '0;
        endcase
    end

    // R9: with every source masked the line stays low
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (&mask) |-> !irq);
    // R9: an unmasked pending flag drives the line
    p_irq_seen_r9: assert property (@(posedge clk) disable iff (rst)
        (flags[EVT_SEC] && !mask[EVT_SEC]) |-> irq);
endmodule

// File: tb/rtc_seconds_core_tb.sv
module rtc_seconds_core_tb;
    import rtcc_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq;
    int                checks = 0;
    int                errors = 0;
    logic [31:0]       t0;

    rtc_seconds_core #(.CAL_DEFAULT(21'h000004)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // called at a negedge; uses the next posedge, returns at the following negedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        checks++;
        if (v !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, v, exp);
        end
    endtask

    task automatic chk_irq(input string req, input logic exp);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s irq actual=%b expected=%b", req, irq, exp);
        end
    endtask

    task automatic t_reset;
        chk("R1", OFS_TIME, 0);
        chk("R1", OFS_EVT, 0);
        chk("R1", OFS_MASK, 32'h3);
        chk("R1", OFS_CAL_RD, 32'h4);
        chk("R1", OFS_CTRL, 0);
        chk_irq("R1", 1'b0);
    endtask

    task automatic t_period;
        wr(OFS_CAL_WR, 32'hFFE0_0004);
        chk("R4", OFS_CAL_RD, 32'h0000_0004);
        chk("R11", OFS_TICK, 0);
        rd(OFS_TIME, t0);
        step(2);
        chk("R11", OFS_TICK, 2);
        step(2);
        chk("R2", OFS_TIME, t0);
        step(1);
        chk("R2", OFS_TIME, t0 + 1);
        step(5);
        chk("R2", OFS_TIME, t0 + 2);
        // mid-second restart, R4
        step(3);
        wr(OFS_CAL_WR, 32'h4);
        step(4);
        chk("R4", OFS_TIME, t0 + 2);
        step(1);
        chk("R4", OFS_TIME, t0 + 3);
    endtask

    task automatic t_fraction;
        wr(OFS_CAL_WR, 32'h0012_0004);
        rd(OFS_TIME, t0);
        step(5);
        chk("R3", OFS_TIME, t0);
        step(1);
        chk("R3", OFS_TIME, t0 + 1);
        step(5);
        chk("R3", OFS_TIME, t0 + 1);
        step(1);
        chk("R3", OFS_TIME, t0 + 2);
        step(4);
        chk("R3", OFS_TIME, t0 + 2);
        step(1);
        chk("R3", OFS_TIME, t0 + 3);
        wr(OFS_CAL_WR, 32'h4);
    endtask

    task automatic t_settime;
        wr(OFS_CAL_WR, 32'h4);
        rd(OFS_TIME, t0);
        wr(OFS_SET_WR, 32'd100);
        chk("R5", OFS_SET_RD, 32'd100);
        step(3);
        chk("R5", OFS_TIME, t0);
        step(1);
        chk("R5", OFS_TIME, 32'd100);
        step(5);
        chk("R5", OFS_TIME, 32'd101);
    endtask

    task automatic t_flags;
        wr(OFS_CAL_WR, 32'h4);
        wr(OFS_EVT, 32'h3);
        chk("R6", OFS_EVT, 0);
        step(3);
        wr(OFS_EVT, 32'h1);
        chk("R6", OFS_EVT, 32'h1);
        wr(OFS_EVT, 32'h1);
        chk("R6", OFS_EVT, 0);
    endtask

    task automatic t_alarm;
        wr(OFS_CAL_WR, 32'h4);
        wr(OFS_SET_WR, 32'd500);
        wr(OFS_ALARM, 32'd501);
        wr(OFS_EVT, 32'h3);
        step(2);
        chk("R7", OFS_TIME, 32'd500);
        chk("R7", OFS_EVT, 32'h1);
        step(5);
        chk("R7", OFS_TIME, 32'd501);
        chk("R7", OFS_EVT, 32'h3);
        chk("R7", OFS_ALARM, 32'd501);
        chk_irq("R9", 1'b0);
    endtask

    task automatic t_mask;
        wr(OFS_UNMASK, 32'h2);
        chk("R8", OFS_MASK, 32'h1);
        chk_irq("R9", 1'b1);
        wr(OFS_EVT, 32'h2);
        chk_irq("R9", 1'b0);
        wr(OFS_DOMASK, 32'h2);
        chk("R8", OFS_MASK, 32'h3);
        wr(OFS_UNMASK, 32'h0);
        chk("R8", OFS_MASK, 32'h3);
        wr(OFS_UNMASK, 32'h1);
        chk("R8", OFS_MASK, 32'h2);
        chk_irq("R9", 1'b1);
        wr(OFS_DOMASK, 32'h3);
    endtask

    task automatic t_ctrl;
        wr(OFS_CTRL, 32'hFFFF_FFFF);
        chk("R10", OFS_CTRL, 32'h8100_0000);
        wr(OFS_CTRL, 32'h0100_0000);
        chk("R10", OFS_CTRL, 32'h0100_0000);
        chk("R12", 8'h30, 0);
        chk("R12", 8'h1C, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_period();
        t_fraction();
        t_settime();
        t_flags();
        t_alarm();
        t_mask();
        t_ctrl();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule